// File: doc/BRIEF.md
# Sticky Interrupt Status Collector with Two-Level Gating

This block gathers single-cycle event pulses from a serial flash controller's transmit FIFO, receive FIFO and descriptor-driven DMA engine. Each event sets a sticky status bit that stays set until software clears it by writing 1 to that bit. A status bit reaches the single interrupt line only when two masks both pass it: an enable register and a separate signal-enable register. Software therefore silences a handled source by clearing its enable bit, and the status bit can stay set while it does so.

Software reaches the status, enable and signal-enable registers through a small read/write port that is decoded by word index. Read data is combinational. A soft reset request returns the masks to zero and leaves the two FIFO-empty events pending. The interrupt output is registered.

Top module: `spi_evt_irq`

## Requirements
- R1: Event input bit n sets status bit n. The bits are: 0 transmit empty, 1 transmit full, 2 transmit threshold, 3 receive empty, 4 receive full, 5 receive threshold, 9 descriptor done, 10 packet complete, 11 DMA error. Status bits 6 to 8 always read 0, and events on those bits are ignored.
- R2: A status bit stays set after its event pulse has gone, for as long as it is neither cleared nor soft-reset.
- R3: `irq_o` is high only if some status bit is set and the same bit is set in both the enable register and the signal-enable register.
- R4: Clearing an enable bit removes that source from `irq_o`, while its status bit stays set.
- R5: A `soft_rst_i` pulse sets the enable and signal-enable registers to 0 and sets status to 0x009 (transmit empty and receive empty only). `irq_o` is low from the following cycle on.
- R6: After reset, and after every pending bit has been cleared, a status read returns 0.
- R7: Writing 1 to a status bit clears it. Writing 0 to a status bit leaves it unchanged.
- R8: If an event and a write-1 clear hit the same status bit in the same cycle, the bit ends up set.
- R9: `irq_o` is registered. It changes on the clock edge after the edge that changed status, enable or signal-enable.
- R10: Register index `addr_i`: 0 is status, 1 is enable, 2 is signal-enable, and 3 reads 0 and ignores writes. A write to enable or signal-enable replaces the whole register, and bits 6 to 8 read back as 0. `rdata_o` shows the selected register in the same cycle as a read request and is 0 otherwise.
- R11: A source whose status bit and enable bit are set but whose signal-enable bit is clear does not raise `irq_o`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| evt_i | input | 12 | Event pulses, one per status bit |
| soft_rst_i | input | 1 | Soft reset request pulse |
| req_i | input | 1 | Register access request |
| we_i | input | 1 | Write (1) or read (0) |
| addr_i | input | 2 | Register index |
| wdata_i | input | 12 | Write data |
| rdata_o | output | 12 | Read data |
| irq_o | output | 1 | Registered interrupt line |

## Verification
The hardest case to reach is an event and a write-1 clear landing on the same status bit on the same clock edge. It only shows up when a pulse and a register write are aligned to the same cycle. The bench drives both from one task on a single falling edge. Another bit is cleared in the same write, so the clear is visibly applied elsewhere while the colliding bit survives. The one-cycle lag of the line is checked by sampling `irq_o` on the falling edge directly after a mask write, and again one cycle later.

// File: rtl/xirq_pkg.sv
package xirq_pkg;
  localparam int unsigned REG_STAT = 0;
  localparam int unsigned REG_EN   = 1;
  localparam int unsigned REG_SIG  = 2;

  localparam int unsigned SRC_TX_EMPTY = 0;
  localparam int unsigned SRC_TX_FULL  = 1;
  localparam int unsigned SRC_TX_THR   = 2;
  localparam int unsigned SRC_RX_EMPTY = 3;
  localparam int unsigned SRC_RX_FULL  = 4;
  localparam int unsigned SRC_RX_THR   = 5;
  localparam int unsigned SRC_DESC     = 9;
  localparam int unsigned SRC_PKT      = 10;
  localparam int unsigned SRC_DMA_ERR  = 11;

  localparam logic [11:0] DEF_IMPL_MASK = 12'hE3F;
  localparam logic [11:0] DEF_SRST_PAT  =
    12'((1 << SRC_TX_EMPTY) | (1 << SRC_RX_EMPTY));
endpackage

// File: rtl/xirq_status_bank.sv
module xirq_status_bank #(
  parameter int unsigned     N         = 12,
  parameter logic [N-1:0]    IMPL_MASK = '1,
  parameter logic [N-1:0]    SRST_PAT  = '0
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [N-1:0] evt_i,
  input  logic [N-1:0] clr_i,
  input  logic         soft_i,
  output logic [N-1:0] stat_o
);
  for (genvar i = 0; i < N; i++) begin : g_bit
    logic bit_q, bit_d;
    // event beats clear; soft reset beats both
    always_comb begin
      bit_d = bit_q;
      if (soft_i)        bit_d = SRST_PAT[i];
      else if (evt_i[i]) bit_d = 1'b1;
      else if (clr_i[i]) bit_d = 1'b0;
    end
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) bit_q <= 1'b0;
      else         bit_q <= bit_d & IMPL_MASK[i];
    end
    assign stat_o[i] = bit_q;
  end
endmodule

// File: rtl/xirq_mask_reg.sv
module xirq_mask_reg #(
  parameter int unsigned  N         = 12,
  parameter logic [N-1:0] IMPL_MASK = '1
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         we_i,
  input  logic [N-1:0] wdata_i,
  input  logic         soft_i,
  output logic [N-1:0] q_o
);
  logic [N-1:0] q;
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     q <= '0;
    else if (soft_i) q <= '0;
    else if (we_i)   q <= wdata_i & IMPL_MASK;
  end
  assign q_o = q;
endmodule

// File: rtl/xirq_line.sv
module xirq_line #(
  parameter int unsigned N = 12
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [N-1:0] stat_i,
  input  logic [N-1:0] en_i,
  input  logic [N-1:0] sig_i,
  output logic         irq_o
);
  logic irq_q;
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) irq_q <= 1'b0;
    else         irq_q <= |(stat_i & en_i & sig_i);
  end
  assign irq_o = irq_q;
endmodule

// File: rtl/spi_evt_irq.sv
module spi_evt_irq
  import xirq_pkg::*;
#(
  parameter int unsigned  NSRC      = 12,
  parameter int unsigned  AW        = 2,
  parameter logic [NSRC-1:0] IMPL_MASK = NSRC'(DEF_IMPL_MASK),
  parameter logic [NSRC-1:0] SRST_PAT  = NSRC'(DEF_SRST_PAT)
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic [NSRC-1:0] evt_i,
  input  logic            soft_rst_i,
  input  logic            req_i,
  input  logic            we_i,
  input  logic [AW-1:0]   addr_i,
  input  logic [NSRC-1:0] wdata_i,
  output logic [NSRC-1:0] rdata_o,
  output logic            irq_o
);
  logic            wr;
  logic            wr_en, wr_sig;
  logic [NSRC-1:0] stat_clr;
  logic [NSRC-1:0] stat_q, en_q, sig_q;

  assign wr       = req_i & we_i;
  assign wr_en    = wr && (addr_i == AW'(REG_EN));
  assign wr_sig   = wr && (addr_i == AW'(REG_SIG));
  assign stat_clr = (wr && (addr_i == AW'(REG_STAT))) ? wdata_i : '0;

  xirq_status_bank #(.N(NSRC), .IMPL_MASK(IMPL_MASK), .SRST_PAT(SRST_PAT)) u_stat (
    .clk_i, .rst_ni, .evt_i, .clr_i(stat_clr), .soft_i(soft_rst_i), .stat_o(stat_q)
  );

  xirq_mask_reg #(.N(NSRC), .IMPL_MASK(IMPL_MASK)) u_en (
    .clk_i, .rst_ni, .we_i(wr_en), .wdata_i, .soft_i(soft_rst_i), .q_o(en_q)
  );

  xirq_mask_reg #(.N(NSRC), .IMPL_MASK(IMPL_MASK)) u_sig (
    .clk_i, .rst_ni, .we_i(wr_sig), .wdata_i, .soft_i(soft_rst_i), .q_o(sig_q)
  );

  xirq_line #(.N(NSRC)) u_line (
    .clk_i, .rst_ni, .stat_i(stat_q), .en_i(en_q), .sig_i(sig_q), .irq_o
  );

  always_comb begin
    rdata_o = '0;
    if (req_i && !we_i) begin
      if (addr_i == AW'(REG_STAT))     rdata_o = stat_q;
      else if (addr_i == AW'(REG_EN))  rdata_o = en_q;
      else if (addr_i == AW'(REG_SIG)) rdata_o = sig_q;
    end
  end
endmodule

// File: rtl/spi_evt_irq_chk.sv
module spi_evt_irq_chk #(
  parameter int unsigned  NSRC      = 12,
  parameter int unsigned  AW        = 2,
  parameter logic [NSRC-1:0] IMPL_MASK = '1
) (
  input logic            clk_i,
  input logic            rst_ni,
  input logic [NSRC-1:0] evt_i,
  input logic            soft_rst_i,
  input logic            req_i,
  input logic            we_i,
  input logic [AW-1:0]   addr_i,
  input logic [NSRC-1:0] stat_i,
  input logic [NSRC-1:0] en_i,
  input logic [NSRC-1:0] sig_i,
  input logic            irq_i
);
  logic            st_wr;
  logic [NSRC-1:0] evt_m;
  logic            live;
  assign st_wr = req_i && we_i && (addr_i == '0);
  assign evt_m = evt_i & IMPL_MASK;
  assign live  = |(stat_i & en_i & sig_i);

  AST_RSVD_ZERO: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (stat_i & ~IMPL_MASK) == '0); // R1
  AST_STICKY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!soft_rst_i && !st_wr) |=> ((stat_i & $past(stat_i)) == $past(stat_i))); // R2
  AST_IRQ_NEEDS_ALL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !live |=> !irq_i); // R3
  AST_IRQ_LAG: assert property (@(posedge clk_i) disable iff (!rst_ni)
    live |=> irq_i); // R9
  AST_SOFT_MASKS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    soft_rst_i |=> (en_i == '0 && sig_i == '0)); // R5
  AST_EVT_WINS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!soft_rst_i && (evt_m != '0)) |=> ((stat_i & $past(evt_m)) == $past(evt_m))); // R8
endmodule

bind spi_evt_irq spi_evt_irq_chk #(.NSRC(NSRC), .AW(AW), .IMPL_MASK(IMPL_MASK)) u_chk (
  .clk_i, .rst_ni, .evt_i, .soft_rst_i, .req_i, .we_i, .addr_i,
  .stat_i(stat_q), .en_i(en_q), .sig_i(sig_q), .irq_i(irq_o)
);

// File: tb/sim_spi_evt_irq.sv
module sim_spi_evt_irq;
  localparam int CLK_PERIOD = 10;

  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic [11:0] evt_i = '0;
  logic        soft_rst_i = 1'b0;
  logic        req_i = 1'b0;
  logic        we_i = 1'b0;
  logic [1:0]  addr_i = '0;
  logic [11:0] wdata_i = '0;
  logic [11:0] rdata_o;
  logic        irq_o;

  int n_chk = 0;
  int n_fail = 0;

  always #(CLK_PERIOD/2) clk_i = ~clk_i;

  spi_evt_irq u0 (.*);

  task automatic chk(input string tag, input logic [11:0] act, input logic [11:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [1:0] a, input logic [11:0] d);
    @(negedge clk_i);
    req_i = 1'b1; we_i = 1'b1; addr_i = a; wdata_i = d;
    @(negedge clk_i);
    req_i = 1'b0; we_i = 1'b0;
  endtask

  task automatic rd(input logic [1:0] a, output logic [11:0] d);
    @(negedge clk_i);
    req_i = 1'b1; we_i = 1'b0; addr_i = a;
    #1 d = rdata_o;
    req_i = 1'b0;
  endtask

  task automatic pulse(input logic [11:0] m);
    @(negedge clk_i);
    evt_i = m;
    @(negedge clk_i);
    evt_i = '0;
  endtask

  task automatic t_reset();
    logic [11:0] v;
    rd(2'd0, v); chk("R6 status after reset", v, 12'h000);
    rd(2'd1, v); chk("R10 enable after reset", v, 12'h000);
    rd(2'd2, v); chk("R10 sig-enable after reset", v, 12'h000);
    chk("R3 irq after reset", {11'd0, irq_o}, 12'h000);
  endtask

  task automatic t_capture();
    logic [11:0] v;
    pulse(12'h004);
    repeat (3) @(negedge clk_i);
    rd(2'd0, v); chk("R2 sticky tx threshold", v, 12'h004);
    pulse(12'h1C0);
    rd(2'd0, v); chk("R1 reserved events ignored", v, 12'h004);
    pulse(12'hE00);
    rd(2'd0, v); chk("R1 dma bits captured", v, 12'hE04);
  endtask

  task automatic t_w1c();
    logic [11:0] v;
    wr(2'd0, 12'h000);
    rd(2'd0, v); chk("R7 write zero no effect", v, 12'hE04);
    wr(2'd0, 12'h200);
    rd(2'd0, v); chk("R7 write one clears", v, 12'hC04);
    wr(2'd0, 12'hFFF);
    rd(2'd0, v); chk("R6 all cleared reads zero", v, 12'h000);
  endtask

  task automatic t_gate();
    logic [11:0] v;
    pulse(12'h400);
    wr(2'd1, 12'h400);
    repeat (2) @(negedge clk_i);
    chk("R11 sig-enable blocks line", {11'd0, irq_o}, 12'h000);
    wr(2'd2, 12'h400);
    chk("R9 irq not yet", {11'd0, irq_o}, 12'h000);
    @(negedge clk_i);
    chk("R3 irq with all three", {11'd0, irq_o}, 12'h001);
    wr(2'd1, 12'h000);
    chk("R9 irq holds one cycle", {11'd0, irq_o}, 12'h001);
    @(negedge clk_i);
    chk("R4 enable clear drops irq", {11'd0, irq_o}, 12'h000);
    rd(2'd0, v); chk("R4 status kept", v, 12'h400);
    wr(2'd1, 12'h400);
    @(negedge clk_i);
    chk("R3 irq back", {11'd0, irq_o}, 12'h001);
    wr(2'd0, 12'h400);
    @(negedge clk_i);
    chk("R7 clear drops irq", {11'd0, irq_o}, 12'h000);
    rd(2'd0, v); chk("R6 nothing pending", v, 12'h000);
  endtask

  task automatic t_race();
    logic [11:0] v;
    pulse(12'h001);
    @(negedge clk_i);
    evt_i = 12'h800;
    req_i = 1'b1; we_i = 1'b1; addr_i = 2'd0; wdata_i = 12'h801;
    @(negedge clk_i);
    evt_i = '0; req_i = 1'b0; we_i = 1'b0;
    rd(2'd0, v); chk("R8 event beats clear", v, 12'h800);
    wr(2'd0, 12'hFFF);
  endtask

  task automatic t_soft();
    logic [11:0] v;
    wr(2'd1, 12'hFFF);
    rd(2'd1, v); chk("R10 enable reserved bits", v, 12'hE3F);
    wr(2'd3, 12'hFFF);
    rd(2'd3, v); chk("R10 index 3 reads zero", v, 12'h000);
    wr(2'd2, 12'hFFF);
    pulse(12'h020);
    @(negedge clk_i);
    chk("R3 irq before soft reset", {11'd0, irq_o}, 12'h001);
    @(negedge clk_i);
    soft_rst_i = 1'b1;
    @(negedge clk_i);
    soft_rst_i = 1'b0;
    @(negedge clk_i);
    chk("R5 irq low after soft reset", {11'd0, irq_o}, 12'h000);
    rd(2'd1, v); chk("R5 enable zeroed", v, 12'h000);
    rd(2'd2, v); chk("R5 sig-enable zeroed", v, 12'h000);
    rd(2'd0, v); chk("R5 status pattern", v, 12'h009);
    wr(2'd1, 12'h001);
    wr(2'd2, 12'h001);
    @(negedge clk_i);
    chk("R2 soft event still pending", {11'd0, irq_o}, 12'h001);
  endtask

  task automatic finish_run();
    $display("  %0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  endtask

  initial begin
    #(CLK_PERIOD * 20000);
    n_chk++; n_fail++;
    $display("FAIL watchdog: actual hung expected done");
    finish_run();
  end

  initial begin
    repeat (3) @(negedge clk_i);
    rst_ni = 1'b1;
    t_reset();
    t_capture();
    t_w1c();
    t_gate();
    t_race();
    t_soft();
    finish_run();
  end
endmodule